// File: doc/BRIEF.md
# Bus Data-Float Turnaround Controller

This block belongs to an external static-memory controller whose chip selects share one data bus. A device that has just been read keeps driving that bus for a short time after the read strobe rises. The block holds off the next access until the bus is free again. Each chip select has its own float-cycle count (0 to 15) and its own optimization bit. When a read finishes, the block loads a window of the programmed float cycles plus one fixed turnaround cycle. For as long as that window is open, it reports the bus as busy.

A new access presents a request together with the length of its setup phase. With optimization off, the request is stalled until the window has fully closed. With optimization on, the setup cycles of the new access may overlap the rest of the window, so the request is stalled only when the setup phase is too short to cover what remains. The grant and stall outputs are combinational on the request. The window state is registered.

The request applies to any next access, on any chip select and in either direction. A read on the same chip select is held exactly like an access on a different one, so the request carries only its setup length.

Top module: `bft_float_guard`

## Requirements
- R1: A pulse on `end_valid` with `end_write`=0 for chip select c opens a window. `busy` is high for exactly F+1 cycles, starting in the cycle after the pulse. F is `cfg_float[4c+3:4c]`.
- R2: With F=0, `busy` is high for exactly one cycle. A request made in that cycle is stalled when optimization is off.
- R3: A pulse on `end_valid` with `end_write`=1 opens no window. `busy` stays low and a request in the next cycle is granted.
- R4: With optimization off (`cfg_opt[c]`=0), a request is stalled in every busy cycle whatever its `req_setup`. It is granted in the first cycle in which `busy` is low.
- R5: With optimization on (`cfg_opt[c]`=1), a request in busy cycle k (k=1 is the first busy cycle) is granted if and only if F+2-k <= `req_setup`. So only the shortfall is stalled.
- R6: F and the optimization bit are taken from the chip select that ended the read, at the cycle of the pulse. The settings of other chip selects have no effect. Later changes to the configuration inputs also have no effect on the open window.
- R7: A read end during an open window restarts the window from the count of the new read's chip select.
- R8: Reset, asserted at any time, closes the window. After reset `busy` is low and the first request is granted at once.
- R9: `grant` = `req_valid` and allowed, and `stall` = `req_valid` and not allowed, in the same cycle as the request. Both are low when there is no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_float | input | NUM_CS*FLOAT_W | Float-cycle count per chip select, c at [4c+3:4c] by default |
| cfg_opt | input | NUM_CS | Optimization enable per chip select |
| end_valid | input | 1 | Pulse: an access's control strobe rose |
| end_cs | input | CS_W | Chip select of the finished access |
| end_write | input | 1 | 1 = finished access was a write |
| req_valid | input | 1 | A new access asks for the bus |
| req_setup | input | SETUP_W | Setup length of the new access in cycles |
| grant | output | 1 | Request may start now |
| stall | output | 1 | Request must wait this cycle |
| busy | output | 1 | Float or turnaround window open |

## Verification
`busy` changes one clock edge after the end pulse. It then stays high for F+1 cycles. `grant` and `stall` follow the request inputs within the same cycle. The bench drives inputs on the falling edge and samples 1 ns later, so every sample sees the state left by the last rising edge plus the present request. In each stimulus vector, the check in busy cycle k is compared against the closed-form rule of R4 or R5. The last check in a vector falls in cycle F+2, where the window has just closed. The reset checks wait for the two-stage synchronous release before the first request.

// File: rtl/bft_pkg.sv
package bft_pkg;
  localparam int unsigned DEF_NUM_CS  = 4;
  localparam int unsigned DEF_FLOAT_W = 4;
  localparam int unsigned DEF_SETUP_W = 6;

  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } acc_dir_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/bft_rst_sync.sv
module bft_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/bft_cfg_select.sv
module bft_cfg_select #(
  parameter int unsigned NUM_CS  = 4,
  parameter int unsigned FLOAT_W = 4,
  localparam int unsigned CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [NUM_CS*FLOAT_W-1:0] cfg_float,
  input  logic [NUM_CS-1:0]         cfg_opt,
  input  logic [CS_W-1:0]           sel_cs,
  output logic [FLOAT_W-1:0]        sel_float,
  output logic                      sel_opt
);
  logic [FLOAT_W-1:0] float_arr [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_unpack
    assign float_arr[g] = cfg_float[g*FLOAT_W +: FLOAT_W];
  end

  always_comb begin
    sel_float = '0;
    sel_opt   = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (sel_cs == CS_W'(i)) begin
        sel_float = float_arr[i];
        sel_opt   = cfg_opt[i];
      end
    end
  end
endmodule

// File: rtl/bft_window_ctr.sv
module bft_window_ctr #(
  parameter int unsigned FLOAT_W = 4,
  localparam int unsigned CNT_W  = FLOAT_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic [FLOAT_W-1:0] arm_float,
  input  logic               arm_opt,
  output logic [CNT_W-1:0]   rem,
  output logic               opt,
  output logic               busy
);
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             opt_q, opt_d;
  logic             ce;

  assign busy = (rem_q != '0);
  assign ce   = arm | busy;

  always_comb begin
    rem_d = rem_q;
    opt_d = opt_q;
    if (arm) begin
      // float cycles plus the fixed turnaround cycle
      rem_d = CNT_W'(arm_float) + CNT_W'(1);
      opt_d = arm_opt;
    end else if (busy) begin
      rem_d = rem_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      opt_q <= 1'b0;
    end else if (ce) begin
      rem_q <= rem_d;
      opt_q <= opt_d;
    end
  end

  assign rem = rem_q;
  assign opt = opt_q;
endmodule

// File: rtl/bft_grant_eval.sv
module bft_grant_eval #(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned SETUP_W = 6,
  localparam int unsigned CMP_W  = bft_pkg::max_u(CNT_W, SETUP_W)
) (
  input  logic [CNT_W-1:0]   rem,
  input  logic               opt,
  input  logic               req_valid,
  input  logic [SETUP_W-1:0] req_setup,
  output logic               grant,
  output logic               stall
);
  logic [CMP_W-1:0] rem_x, setup_x;
  logic             allowed;

  assign rem_x   = CMP_W'(rem);
  assign setup_x = CMP_W'(req_setup);

  always_comb begin
    if (rem_x == '0)  allowed = 1'b1;
    else if (opt)     allowed = (rem_x <= setup_x);
    else              allowed = 1'b0;
  end

  assign grant = req_valid & allowed;
  assign stall = req_valid & ~allowed;
endmodule

// File: rtl/bft_float_guard.sv
module bft_float_guard #(
  parameter int unsigned NUM_CS  = bft_pkg::DEF_NUM_CS,
  parameter int unsigned FLOAT_W = bft_pkg::DEF_FLOAT_W,
  parameter int unsigned SETUP_W = bft_pkg::DEF_SETUP_W,
  localparam int unsigned CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int unsigned CNT_W  = FLOAT_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CS*FLOAT_W-1:0] cfg_float,
  input  logic [NUM_CS-1:0]         cfg_opt,
  input  logic                      end_valid,
  input  logic [CS_W-1:0]           end_cs,
  input  logic                      end_write,
  input  logic                      req_valid,
  input  logic [SETUP_W-1:0]        req_setup,
  output logic                      grant,
  output logic                      stall,
  output logic                      busy
);
  import bft_pkg::*;

  logic               rst_int_n;
  logic [FLOAT_W-1:0] sel_float;
  logic               sel_opt;
  logic               arm;
  logic [CNT_W-1:0]   rem_w;
  logic               opt_w;

  bft_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_int_n)
  );

  bft_cfg_select #(.NUM_CS(NUM_CS), .FLOAT_W(FLOAT_W)) u_sel (
    .cfg_float(cfg_float),
    .cfg_opt  (cfg_opt),
    .sel_cs   (end_cs),
    .sel_float(sel_float),
    .sel_opt  (sel_opt)
  );

  assign arm = end_valid & (acc_dir_e'(end_write) == DIR_READ);

  bft_window_ctr #(.FLOAT_W(FLOAT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .arm      (arm),
    .arm_float(sel_float),
    .arm_opt  (sel_opt),
    .rem      (rem_w),
    .opt      (opt_w),
    .busy     (busy)
  );

  bft_grant_eval #(.CNT_W(CNT_W), .SETUP_W(SETUP_W)) u_eval (
    .rem      (rem_w),
    .opt      (opt_w),
    .req_valid(req_valid),
    .req_setup(req_setup),
    .grant    (grant),
    .stall    (stall)
  );
endmodule

// File: rtl/bft_float_guard_chk.sv
module bft_float_guard_chk #(
  parameter int unsigned CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             end_valid,
  input logic             end_write,
  input logic             req_valid,
  input logic             grant,
  input logic             stall,
  input logic             busy,
  input logic             opt,
  input logic [CNT_W-1:0] rem
);
  // R1
  read_end_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (end_valid && !end_write) |=> busy);

  // R1
  window_counts_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(end_valid && !end_write)) |=> (rem == CNT_W'($past(rem) - CNT_W'(1))));

  // R3
  write_end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (end_valid && end_write && !busy) |=> !busy);

  // R4
  no_grant_plain_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !opt) |-> !grant);

  // R8
  idle_grants_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |-> grant);

  // R9
  grant_stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && stall));

  // R9
  no_req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!grant && !stall));
endmodule

bind bft_float_guard bft_float_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .end_valid(end_valid),
  .end_write(end_write),
  .req_valid(req_valid),
  .grant    (grant),
  .stall    (stall),
  .busy     (busy),
  .opt      (opt_w),
  .rem      (rem_w)
);

// File: tb/bft_float_guard_tb_top.sv
module bft_float_guard_tb_top;
  localparam int NCS = 4;
  localparam int FW  = 4;
  localparam int SW  = 6;

  typedef struct packed {
    logic [1:0] cs;
    logic [3:0] fl;
    logic       op;
    logic [5:0] su;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{cs:2'd0, fl:4'd3,  op:1'b0, su:6'd5},
    '{cs:2'd1, fl:4'd0,  op:1'b0, su:6'd0},
    '{cs:2'd2, fl:4'd15, op:1'b0, su:6'd63},
    '{cs:2'd3, fl:4'd6,  op:1'b1, su:6'd2},
    '{cs:2'd1, fl:4'd4,  op:1'b1, su:6'd10},
    '{cs:2'd0, fl:4'd0,  op:1'b1, su:6'd0},
    '{cs:2'd2, fl:4'd15, op:1'b1, su:6'd15},
    '{cs:2'd3, fl:4'd9,  op:1'b1, su:6'd0}
  };

  logic            clk;
  logic            rst_n;
  logic [NCS*FW-1:0] cfg_float;
  logic [NCS-1:0]  cfg_opt;
  logic            end_valid;
  logic [1:0]      end_cs;
  logic            end_write;
  logic            req_valid;
  logic [SW-1:0]   req_setup;
  logic            grant, stall, busy;

  int n_chk;
  int n_fail;
  bit finished;

  bft_float_guard #(.NUM_CS(NCS), .FLOAT_W(FW), .SETUP_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_float(cfg_float), .cfg_opt(cfg_opt),
    .end_valid(end_valid), .end_cs(end_cs), .end_write(end_write),
    .req_valid(req_valid), .req_setup(req_setup),
    .grant(grant), .stall(stall), .busy(busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // sample busy/grant/stall 1 ns after the falling edge
  task automatic sample(input string req, input logic e_busy, input logic e_grant);
    #1;
    check(req, "busy", busy, e_busy);
    check(req, "grant", grant, e_grant);
    check(req, "stall", stall, req_valid & ~e_grant);
  endtask

  task automatic set_cfg(input int cs, input logic [3:0] f, input logic o);
    cfg_float[cs*FW +: FW] = f;
    cfg_opt[cs] = o;
  endtask

  task automatic end_pulse(input int cs, input logic wr);
    end_valid = 1'b1; end_cs = 2'(cs); end_write = wr;
    @(negedge clk);
    end_valid = 1'b0; end_write = 1'b0;
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0;
    cfg_float = '0; cfg_opt = '0;
    end_valid = 1'b0; end_cs = '0; end_write = 1'b0;
    req_valid = 1'b0; req_setup = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // R8: after reset the window is closed, first request granted
    req_valid = 1'b1; req_setup = '0;
    sample("R8", 1'b0, 1'b1);
    // R9: no request -> both quiet
    req_valid = 1'b0;
    sample("R9", 1'b0, 1'b0);
    @(negedge clk);

    // table walk: R1, R2, R4, R5, R6
    for (int v = 0; v < NV; v++) begin
      for (int c = 0; c < NCS; c++) set_cfg(c, 4'd15, ~VECS[v].op);
      set_cfg(VECS[v].cs, VECS[v].fl, VECS[v].op);
      idle(2);
      end_pulse(VECS[v].cs, 1'b0);
      for (int k = 1; k <= VECS[v].fl + 2; k++) begin
        int   remk;
        logic eg;
        remk = VECS[v].fl + 2 - k;
        eg = VECS[v].op ? (remk <= VECS[v].su) : (remk == 0);
        req_valid = 1'b1; req_setup = VECS[v].su;
        if (VECS[v].fl == 0)   sample("R2", k <= 1, eg);
        else if (VECS[v].op)   sample("R5", k <= VECS[v].fl + 1, eg);
        else                   sample("R1_R4_R6", k <= VECS[v].fl + 1, eg);
        @(negedge clk);
      end
      req_valid = 1'b0;
    end

    // R3: a write end opens no window
    set_cfg(0, 4'd7, 1'b0);
    idle(2);
    end_pulse(0, 1'b1);
    req_valid = 1'b1; req_setup = '0;
    sample("R3", 1'b0, 1'b1);
    @(negedge clk);
    req_valid = 1'b0;

    // R6: configuration change after the pulse does not alter the window
    set_cfg(1, 4'd3, 1'b0);
    idle(1);
    end_pulse(1, 1'b0);
    set_cfg(1, 4'd0, 1'b1);
    for (int k = 1; k <= 5; k++) begin
      req_valid = 1'b1; req_setup = 6'd63;
      sample("R6", k <= 4, k == 5);
      @(negedge clk);
    end
    req_valid = 1'b0;

    // R7: second read end during the window restarts it from the new count
    set_cfg(0, 4'd5, 1'b0);
    set_cfg(2, 4'd1, 1'b0);
    idle(1);
    end_pulse(0, 1'b0);
    sample("R7", 1'b1, 1'b0);
    @(negedge clk);
    end_pulse(2, 1'b0);
    for (int k = 1; k <= 3; k++) begin
      req_valid = 1'b1; req_setup = '0;
      sample("R7", k <= 2, k == 3);
      @(negedge clk);
    end
    req_valid = 1'b0;

    // R8: reset during an open window
    set_cfg(3, 4'd15, 1'b0);
    idle(1);
    end_pulse(3, 1'b0);
    sample("R8", 1'b1, 1'b0);
    rst_n = 1'b0;
    sample("R8", 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    req_valid = 1'b1; req_setup = '0;
    sample("R8", 1'b0, 1'b1);
    @(negedge clk);
    req_valid = 1'b0;
    idle(2);

    finish_run();
  end
endmodule